// File: doc/BRIEF.md
# Compressed Control-Transfer Execution Unit

This unit executes the five 16-bit compressed control-transfer instructions: the unconditional PC-relative jump, the register-indirect jump, the register-indirect jump that writes a link, and the two branches that test one register against zero. Each cycle it can accept one instruction, marked by a valid strobe, together with the PC that instruction was fetched from. It sends the index of the register it needs to an external register file on `rs_idx`, in the same cycle, and it takes the value back on `rs_data`.

One clock edge after acceptance, the unit presents the next PC, an optional link write to the register file (enable, index and data), and a flag for any encoding it does not execute. Branch and jump offsets are rebuilt from their scattered instruction bits and then sign-extended. The register width is the parameter `XLEN`. Sequential flow advances the PC by 2, because every instruction here is two bytes long.

Top module: `ctx_unit`

## Requirements
- R1: `out_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 otherwise. All result outputs are registered, so they change only at that edge. Reset clears `out_valid` and `out_wr_en`.
- R2: An instruction with bits[15:13]=101 and bits[1:0]=01 (jump) sets the next PC to PC plus its sign-extended offset. It writes no register and is not illegal.
- R3: The jump offset is built as follows. imm[11]=bit12, imm[10]=bit8, imm[9:8]=bits10:9, imm[7]=bit6, imm[6]=bit7, imm[5]=bit2, imm[4]=bit11, imm[3:1]=bits5:3 and imm[0]=0. It is sign-extended from imm[11], so the range is -2048 to +2046.
- R4: bits[15:13]=110 with op 01 (branch-if-zero) is taken when the source value is 0. bits[15:13]=111 with op 01 (branch-if-nonzero) is taken when the source value is not 0. A taken branch sets the next PC to PC plus the offset. Neither branch writes a register.
- R5: The branch offset is built as follows. imm[8]=bit12, imm[7:6]=bits6:5, imm[5]=bit2, imm[4:3]=bits11:10, imm[2:1]=bits4:3 and imm[0]=0. It is sign-extended from imm[8], so the range is -256 to +254.
- R6: A branch that is not taken sets the next PC to PC+2.
- R7: For both branches, `rs_idx` is 8 plus bits[9:7], which covers only registers 8 to 15.
- R8: bits[15:12]=1000, bits[6:2]=0 and op 10 (indirect jump) drives `rs_idx` with bits[11:7]. It sets the next PC to `rs_data` and writes no register.
- R9: bits[15:12]=1001, bits[6:2]=0 and op 10 (indirect jump with link) behaves like R8. It also writes PC+2 to register 1.
- R10: An indirect jump of either kind with bits[11:7]=0 is illegal. It gives `out_illegal`=1, next PC = PC+2 and no write.
- R11: Every other encoding is illegal. It gives `out_illegal`=1, next PC = PC+2 and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_instr | input | 16 | Compressed instruction word |
| in_pc | input | XLEN | Address of the instruction |
| rs_idx | output | 5 | Source register index for the register file (combinational) |
| rs_data | input | XLEN | Value of register `rs_idx`, same cycle |
| out_valid | output | 1 | Result outputs are meaningful |
| out_next_pc | output | XLEN | PC of the next instruction |
| out_wr_en | output | 1 | Link write request |
| out_wr_idx | output | 5 | Link destination register |
| out_wr_data | output | XLEN | Link value |
| out_illegal | output | 1 | Instruction not executed |

## Verification
The assertions assume that `in_pc` and `rs_data` hold steady during the cycle in which `in_valid` is high. They also assume that `rs_data` already reflects the current `rs_idx` in that cycle, which means a register file with combinational read, with register 0 reading as zero. The bench keeps to both assumptions. It changes its inputs only at falling edges, and it answers `rs_idx` from its own register array through a continuous assignment. It also leaves `in_valid` low between instructions, except in one back-to-back scenario where every input is refreshed at each falling edge.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  typedef enum logic [2:0] {
    K_ILL  = 3'd0,
    K_JMP  = 3'd1,
    K_BEQZ = 3'd2,
    K_BNEZ = 3'd3,
    K_JR   = 3'd4,
    K_JALR = 3'd5
  } ctx_kind_e;

  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned CJ_OFF_W  = 12;
  localparam int unsigned CB_OFF_W  = 9;
  localparam logic [REG_IDX_W-1:0] LINK_REG = 5'd1;

  // Unscramble the unconditional jump offset (bit 0 always zero).
  function automatic logic [CJ_OFF_W-1:0] cj_offset(input logic [15:0] w);
    return {w[12], w[8], w[10:9], w[6], w[7], w[2], w[11], w[5:3], 1'b0};
  endfunction

  // Unscramble the branch offset (bit 0 always zero).
  function automatic logic [CB_OFF_W-1:0] cb_offset(input logic [15:0] w);
    return {w[12], w[6:5], w[2], w[11:10], w[4:3], 1'b0};
  endfunction

  // Short register field selects x8..x15.
  function automatic logic [REG_IDX_W-1:0] short_reg(input logic [2:0] f);
    return {2'b01, f};
  endfunction

endpackage

// File: rtl/ctx_decode.sv
module ctx_decode
  import ctx_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [15:0]          instr,
  output ctx_kind_e            kind,
  output logic [REG_IDX_W-1:0] src_idx,
  output logic [XLEN-1:0]      offset
);
  logic [1:0] quad;
  logic [2:0] f3;
  logic [3:0] f4;
  logic [4:0] rs1_f;
  logic       rs2_zero;
  logic [CJ_OFF_W-1:0] cj_raw;
  logic [CB_OFF_W-1:0] cb_raw;

  assign quad     = instr[1:0];
  assign f3       = instr[15:13];
  assign f4       = instr[15:12];
  assign rs1_f    = instr[11:7];
  assign rs2_zero = (instr[6:2] == 5'd0);
  assign cj_raw   = cj_offset(instr);
  assign cb_raw   = cb_offset(instr);

  always_comb begin
    kind = K_ILL;
    if (quad == 2'b01) begin
      unique case (f3)
        3'b101:  kind = K_JMP;
        3'b110:  kind = K_BEQZ;
        3'b111:  kind = K_BNEZ;
        default: kind = K_ILL;
      endcase
    end else if (quad == 2'b10 && rs2_zero && rs1_f != 5'd0) begin
      if (f4 == 4'b1000)      kind = K_JR;
      else if (f4 == 4'b1001) kind = K_JALR;
    end
  end

  always_comb begin
    src_idx = '0;
    offset  = '0;
    case (kind)
      K_JMP:         offset  = {{(XLEN-CJ_OFF_W){cj_raw[CJ_OFF_W-1]}}, cj_raw};
      K_BEQZ,K_BNEZ: begin
        src_idx = short_reg(instr[9:7]);
        offset  = {{(XLEN-CB_OFF_W){cb_raw[CB_OFF_W-1]}}, cb_raw};
      end
      K_JR, K_JALR:  src_idx = rs1_f;
      default: ;
    endcase
  end
endmodule

// File: rtl/ctx_target.sv
module ctx_target
  import ctx_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  ctx_kind_e            kind,
  input  logic [XLEN-1:0]      pc,
  input  logic [XLEN-1:0]      src_val,
  input  logic [XLEN-1:0]      offset,
  output logic [XLEN-1:0]      next_pc,
  output logic                 link_en,
  output logic [XLEN-1:0]      link_val,
  output logic                 illegal,
  output logic                 br_taken
);
  localparam logic [XLEN-1:0] STEP = XLEN'(2);

  logic [XLEN-1:0] seq_pc;
  logic            src_zero;

  assign seq_pc   = pc + STEP;
  assign src_zero = (src_val == '0);
  assign br_taken = (kind == K_BEQZ && src_zero) || (kind == K_BNEZ && !src_zero);
  assign link_val = seq_pc;

  always_comb begin
    next_pc = seq_pc;
    link_en = 1'b0;
    illegal = 1'b0;
    case (kind)
      K_JMP:          next_pc = pc + offset;
      K_BEQZ, K_BNEZ: next_pc = br_taken ? (pc + offset) : seq_pc;
      K_JR:           next_pc = src_val;
      K_JALR: begin
        next_pc = src_val;
        link_en = 1'b1;
      end
      default:        illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/ctx_unit.sv
module ctx_unit
  import ctx_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [15:0]          in_instr,
  input  logic [XLEN-1:0]      in_pc,
  output logic [4:0]           rs_idx,
  input  logic [XLEN-1:0]      rs_data,
  output logic                 out_valid,
  output logic [XLEN-1:0]      out_next_pc,
  output logic                 out_wr_en,
  output logic [4:0]           out_wr_idx,
  output logic [XLEN-1:0]      out_wr_data,
  output logic                 out_illegal
);
  ctx_kind_e       kind;
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] nxt_pc;
  logic            link_en;
  logic [XLEN-1:0] link_val;
  logic            illegal;
  logic            br_taken;

  ctx_decode #(.XLEN(XLEN)) u_dec (
    .instr   (in_instr),
    .kind    (kind),
    .src_idx (rs_idx),
    .offset  (offset)
  );

  ctx_target #(.XLEN(XLEN)) u_tgt (
    .kind     (kind),
    .pc       (in_pc),
    .src_val  (rs_data),
    .offset   (offset),
    .next_pc  (nxt_pc),
    .link_en  (link_en),
    .link_val (link_val),
    .illegal  (illegal),
    .br_taken (br_taken)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_next_pc <= '0;
      out_wr_en   <= 1'b0;
      out_wr_idx  <= '0;
      out_wr_data <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_next_pc <= nxt_pc;
        out_wr_en   <= link_en;
        out_wr_idx  <= link_en ? LINK_REG : '0;
        out_wr_data <= link_val;
        out_illegal <= illegal;
      end else begin
        out_wr_en   <= 1'b0;
      end
    end
  end

  // R1: result appears exactly one edge after acceptance
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7: branches only reach x8..x15
  p_short_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (kind == K_BEQZ || kind == K_BNEZ)) |-> (rs_idx[4:3] == 2'b01));
  // R9: link writes go to x1 with the sequential PC
  p_link_x1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wr_en) |-> (out_wr_idx == 5'd1 && out_wr_data == $past(in_pc) + XLEN'(2)));
  // R10: indirect jumps through x0 are rejected
  p_x0_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_instr[1:0] == 2'b10 && in_instr[15:13] == 3'b100 &&
     in_instr[11:7] == 5'd0 && in_instr[6:2] == 5'd0) |=> out_illegal);
  // R11: illegal results never write and step by 2
  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (!out_wr_en && out_next_pc == $past(in_pc) + XLEN'(2)));
  // R6: a not-taken branch steps by 2
  p_fallthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (kind == K_BEQZ || kind == K_BNEZ) && !br_taken) |=>
      (out_next_pc == $past(in_pc) + XLEN'(2)));
endmodule

// File: tb/sim_ctx_unit.sv
`timescale 1ns/1ps
module sim_ctx_unit;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [15:0]     in_instr = '0;
  logic [XLEN-1:0] in_pc = '0;
  logic [4:0]      rs_idx;
  logic [XLEN-1:0] rs_data;
  logic            out_valid, out_wr_en, out_illegal;
  logic [XLEN-1:0] out_next_pc, out_wr_data;
  logic [4:0]      out_wr_idx;
  logic [XLEN-1:0] rf [32];

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  assign rs_data = (rs_idx == 5'd0) ? '0 : rf[rs_idx];

  ctx_unit #(.XLEN(XLEN)) u0 (
    .clk, .rst_n, .in_valid, .in_instr, .in_pc, .rs_idx, .rs_data,
    .out_valid, .out_next_pc, .out_wr_en, .out_wr_idx, .out_wr_data, .out_illegal
  );

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Encoders: place offset bits into the instruction word.
  function automatic logic [15:0] enc_jmp(input int off);
    logic [15:0] w;
    logic [11:0] o;
    o = 12'(off);
    w = 16'h0001;
    w[15:13] = 3'b101;
    w[12] = o[11]; w[8] = o[10]; w[10] = o[9]; w[9] = o[8];
    w[6] = o[7]; w[7] = o[6]; w[2] = o[5]; w[11] = o[4];
    w[5] = o[3]; w[4] = o[2]; w[3] = o[1];
    return w;
  endfunction

  function automatic logic [15:0] enc_br(input logic nz, input logic [2:0] r, input int off);
    logic [15:0] w;
    logic [8:0] o;
    o = 9'(off);
    w = 16'h0001;
    w[15:13] = nz ? 3'b111 : 3'b110;
    w[9:7] = r;
    w[12] = o[8]; w[6] = o[7]; w[5] = o[6]; w[2] = o[5];
    w[11] = o[4]; w[10] = o[3]; w[4] = o[2]; w[3] = o[1];
    return w;
  endfunction

  function automatic logic [15:0] enc_ind(input logic link, input logic [4:0] r);
    return {3'b100, link, r, 5'd0, 2'b10};
  endfunction

  // Drive one instruction, then check the registered result.
  task automatic run(input string req, input logic [15:0] w, input logic [XLEN-1:0] pc,
                     input logic [4:0] exp_idx, input logic [XLEN-1:0] exp_pc,
                     input logic exp_wr, input logic [XLEN-1:0] exp_wd, input logic exp_ill);
    @(negedge clk);
    in_valid = 1'b1; in_instr = w; in_pc = pc;
    #1;
    if (!exp_ill) chk({req, " rs_idx"}, XLEN'(rs_idx), XLEN'(exp_idx));
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 valid", XLEN'(out_valid), 1);
    chk({req, " next_pc"}, out_next_pc, exp_pc);
    chk({req, " wr_en"}, XLEN'(out_wr_en), XLEN'(exp_wr));
    chk({req, " illegal"}, XLEN'(out_illegal), XLEN'(exp_ill));
    if (exp_wr) begin
      chk({req, " wr_idx"}, XLEN'(out_wr_idx), 1);
      chk({req, " wr_data"}, out_wr_data, exp_wd);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset valid", XLEN'(out_valid), 0);
    chk("R1 reset wr_en", XLEN'(out_wr_en), 0);
  endtask

  task automatic t_jump();
    int offs[6] = '{0, 2, -2, 2046, -2048, 1366};
    foreach (offs[i]) begin
      logic [XLEN-1:0] pc = 32'h0001_0000 + 32'(i * 64);
      run("R2 R3 jump", enc_jmp(offs[i]), pc, 5'd0, pc + 32'(offs[i]), 1'b0, '0, 1'b0);
    end
  endtask

  task automatic t_branch();
    int offs[5] = '{254, -256, 4, -6, 170};
    for (int r = 0; r < 8; r++) begin
      rf[8 + r] = (r % 2 == 0) ? '0 : 32'hdead_0000 + 32'(r);
    end
    foreach (offs[i]) begin
      for (int r = 0; r < 8; r += 3) begin
        for (int nz = 0; nz < 2; nz++) begin
          logic [XLEN-1:0] pc = 32'h0000_4000 + 32'(i * 16);
          logic zero = (rf[8 + r] == 0);
          logic taken = nz ? !zero : zero;
          run(taken ? "R4 R5 branch taken" : "R6 branch not taken",
              enc_br(nz[0], 3'(r), offs[i]), pc, 5'(8 + r),
              taken ? pc + 32'(offs[i]) : pc + 2, 1'b0, '0, 1'b0);
        end
      end
    end
  endtask

  task automatic t_branch_idx();
    for (int r = 0; r < 8; r++)
      run("R7 short index", enc_br(1'b1, 3'(r), 8), 32'h100, 5'(8 + r),
          (rf[8 + r] != 0) ? 32'h108 : 32'h102, 1'b0, '0, 1'b0);
  endtask

  task automatic t_indirect();
    for (int r = 1; r < 32; r += 5) begin
      rf[r] = 32'h8000_0000 + 32'(r * 4);
      run("R8 jr", enc_ind(1'b0, 5'(r)), 32'h2000, 5'(r), rf[r], 1'b0, '0, 1'b0);
      run("R9 jalr", enc_ind(1'b1, 5'(r)), 32'hffff_fffe, 5'(r), rf[r], 1'b1, 32'h0, 1'b0);
    end
  endtask

  task automatic t_x0();
    run("R10 jr x0", enc_ind(1'b0, 5'd0), 32'h300, 5'd0, 32'h302, 1'b0, '0, 1'b1);
    run("R10 jalr x0", enc_ind(1'b1, 5'd0), 32'h400, 5'd0, 32'h402, 1'b0, '0, 1'b1);
  endtask

  task automatic t_other();
    run("R11 mv-like", 16'h8086, 32'h500, 5'd0, 32'h502, 1'b0, '0, 1'b1);
    run("R11 add-like", 16'h9086, 32'h600, 5'd0, 32'h602, 1'b0, '0, 1'b1);
    run("R11 quadrant0", 16'hA001 & 16'hFFFC, 32'h700, 5'd0, 32'h702, 1'b0, '0, 1'b1);
    run("R11 funct3 100", 16'h8001, 32'h800, 5'd0, 32'h802, 1'b0, '0, 1'b1);
    run("R11 full word", 16'hFFFF, 32'h900, 5'd0, 32'h902, 1'b0, '0, 1'b1);
  endtask

  task automatic t_back2back();
    @(negedge clk);
    in_valid = 1'b1; in_instr = enc_jmp(10); in_pc = 32'h1000;
    @(negedge clk);
    chk("R1 b2b first", out_next_pc, 32'h100a);
    in_instr = enc_jmp(-20); in_pc = 32'h2000;
    @(negedge clk);
    chk("R1 b2b valid", XLEN'(out_valid), 1);
    chk("R1 b2b second", out_next_pc, 32'h1fec);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1 idle", XLEN'(out_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_jump();
    t_branch();
    t_branch_idx();
    t_indirect();
    t_x0();
    t_other();
    t_back2back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule